// File: doc/BRIEF.md
# Oscillator Drift Check Counter

This block lets an external host check whether an on-chip oscillator is drifting. On the system clock the host writes a 2-bit command that picks one of two free-running oscillators: the fast measurement clock or the slow wake-up clock. The block then counts that oscillator's rising edges inside the oscillator's own clock domain. The host starts a timer on its own timebase at the same moment. Later it writes a stop command, waits for the result flag and reads the 16-bit count. It then compares the count with the elapsed time it measured itself.

Commands reach each oscillator domain as a level that passes through a two-flop synchroniser. The counter core returns an acknowledge level, which is synchronised back. The result is taken into the system domain only after the acknowledge shows that the count is frozen, so every bit of the read value comes from the same moment. Nothing starts without a host write. A write that arrives while a handshake is still in flight is kept in a one-entry slot and applied once the handshake finishes.

Top module: `osc_drift_counter`

## Requirements
- R1: Writing command code 1 starts counting rising edges of the fast oscillator. Writing code 2 starts counting the slow oscillator. Either start clears the readout to 0 and clears the result flag in the cycle after the write.
- R2: Writing code 3 while counting stops the count. Once the stop handshake completes, the result flag goes to 1 and the readout holds the frozen count. It stays unchanged until a later command changes it.
- R3: The count saturates at 0xFFFF and does not wrap.
- R4: Writing code 0 cancels any count. After the cancel completes, the busy flag is 0, the result flag is 0 and the readout is 0.
- R5: The busy flag is 1 from the cycle after an accepted start until the stop or cancel handshake completes. Busy never rises unless a command has been written.
- R6: While counting, writing the start code of the other oscillator stops the current count and restarts from zero on the new source. Writing the start code of the source already running has no effect.
- R7: A command written while a start or stop handshake is in flight is held. The most recent such command is applied once the handshake completes.
- R8: After reset the readout is 0, busy is 0 and the result flag is 0.
- R9: Writing code 3 while no count is running leaves the readout and the result flag unchanged.
- R10: The frozen count equals the number of oscillator rising edges in the window between the start and stop writes, to within four edges. The error comes from synchroniser latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, all domains |
| hf_osc_clk | input | 1 | Fast measurement oscillator to be counted |
| lp_osc_clk | input | 1 | Slow wake-up oscillator to be counted |
| cmd_wr | input | 1 | Command write strobe, one system cycle |
| cmd_code | input | 2 | Command: 0 cancel, 1 fast, 2 slow, 3 stop |
| count_o | output | 16 | Frozen count readout |
| busy_o | output | 1 | Counting or handshake in progress |
| ready_o | output | 1 | Readout holds a completed count |

## Verification
A core that misses the start clear, or that keeps counting after the stop level falls, shows up as a readout far outside the expected edge window on the very first stop. A wrong saturation shows up as a small number in place of 0xFFFF after a long run. A control state that loses the stop or the pending command leaves busy stuck at 1, which the bench's poll loop detects within a few hundred system cycles. A state that drops the result, or that keeps the wrong source, shows either a zero readout with the flag set or a count that matches the wrong oscillator's period. Each of these is visible at the ports within one to two windows after the command.

// File: rtl/osc_cnt_pkg.sv
`timescale 1ns/1ps
package osc_cnt_pkg;
    localparam int CMD_W = 2;
    localparam int N_SRC = 2;

    localparam logic [CMD_W-1:0] CMD_CANCEL = 2'd0;
    localparam logic [CMD_W-1:0] CMD_FAST   = 2'd1;
    localparam logic [CMD_W-1:0] CMD_SLOW   = 2'd2;
    localparam logic [CMD_W-1:0] CMD_STOP   = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_RUN,
        ST_DRAIN
    } ctl_state_e;

    typedef enum logic [1:0] {
        ACT_HOLD,
        ACT_CLEAR,
        ACT_RESTART
    } drain_act_e;
endpackage

// File: rtl/osc_cnt_sync.sv
`timescale 1ns/1ps
module osc_cnt_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= din;
            for (int i = 1; i < STAGES; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/osc_cnt_core.sv
`timescale 1ns/1ps
module osc_cnt_core #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             osc_clk,
    input  logic             rst_n,
    input  logic             run_req,
    output logic             ack_o,
    output logic [CNT_W-1:0] cnt_o
);
    typedef struct packed {
        logic             ack;
        logic [CNT_W-1:0] cnt;
    } core_regs_t;

    core_regs_t q, d;
    logic       run_sync;

    osc_cnt_sync #(.STAGES(SYNC_STAGES), .WIDTH(1)) u_run_sync (
        .clk  (osc_clk),
        .rst_n(rst_n),
        .din  (run_req),
        .dout (run_sync)
    );

    always_comb begin
        d = q;
        if (run_sync && !q.ack) begin
            d.ack = 1'b1;
            d.cnt = '0;
        end else if (run_sync) begin
            if (q.cnt != '1) begin
                d.cnt = q.cnt + 1'b1;
            end
        end else begin
            d.ack = 1'b0;
        end
    end

    always_ff @(posedge osc_clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign ack_o = q.ack;
    assign cnt_o = q.cnt;

    // R3: a full counter stays full
    assert_no_wrap_R3: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (q.ack && q.cnt == '1) |=> (q.cnt == '1));

    // R1: a new start begins from zero
    assert_start_clear_R1: assert property (@(posedge osc_clk) disable iff (!rst_n)
        $rose(q.ack) |-> (q.cnt == '0));

    // R2: once the acknowledge is low the count is frozen
    assert_frozen_R2: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (!q.ack && !run_sync) |=> $stable(q.cnt));
endmodule

// File: rtl/osc_cnt_ctrl.sv
`timescale 1ns/1ps
module osc_cnt_ctrl
    import osc_cnt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cmd_wr,
    input  logic [CMD_W-1:0]            cmd_code,
    input  logic [N_SRC-1:0]            ack_sync,
    input  logic [N_SRC-1:0][CNT_W-1:0] src_cnt,
    output logic [N_SRC-1:0]            run_req,
    output logic [CNT_W-1:0]            count_o,
    output logic                        busy_o,
    output logic                        ready_o
);
    typedef struct packed {
        ctl_state_e       state;
        logic             sel;
        logic             nsel;
        drain_act_e       act;
        logic [N_SRC-1:0] run;
        logic [CNT_W-1:0] count;
        logic             valid;
        logic             pend_v;
        logic [CMD_W-1:0] pend_code;
    } ctl_regs_t;

    ctl_regs_t        q, d;
    logic             cmd_v;
    logic [CMD_W-1:0] cmd;
    logic             take;
    logic             new_sel;

    assign cmd_v   = cmd_wr | q.pend_v;
    assign cmd     = cmd_wr ? cmd_code : q.pend_code;
    assign take    = (q.state == ST_IDLE) || (q.state == ST_RUN);
    assign new_sel = (cmd == CMD_SLOW);

    always_comb begin
        d = q;
        if (take) begin
            d.pend_v = 1'b0;
        end else if (cmd_wr) begin
            d.pend_v    = 1'b1;
            d.pend_code = cmd_code;
        end

        case (q.state)
            ST_IDLE: begin
                if (cmd_v) begin
                    if (cmd == CMD_FAST || cmd == CMD_SLOW) begin
                        d.sel          = new_sel;
                        d.run          = '0;
                        d.run[new_sel] = 1'b1;
                        d.count        = '0;
                        d.valid        = 1'b0;
                        d.state        = ST_START;
                    end else if (cmd == CMD_CANCEL) begin
                        d.count = '0;
                        d.valid = 1'b0;
                    end
                end
            end
            ST_START: begin
                if (ack_sync[q.sel]) begin
                    d.state = ST_RUN;
                end
            end
            ST_RUN: begin
                if (cmd_v) begin
                    if (cmd == CMD_FAST || cmd == CMD_SLOW) begin
                        if (new_sel != q.sel) begin
                            d.run   = '0;
                            d.nsel  = new_sel;
                            d.act   = ACT_RESTART;
                            d.state = ST_DRAIN;
                        end
                    end else begin
                        d.run   = '0;
                        d.act   = (cmd == CMD_STOP) ? ACT_HOLD : ACT_CLEAR;
                        d.state = ST_DRAIN;
                    end
                end
            end
            ST_DRAIN: begin
                if (!ack_sync[q.sel]) begin
                    case (q.act)
                        ACT_HOLD: begin
                            d.count = src_cnt[q.sel];
                            d.valid = 1'b1;
                            d.state = ST_IDLE;
                        end
                        ACT_RESTART: begin
                            d.sel         = q.nsel;
                            d.run[q.nsel] = 1'b1;
                            d.count       = '0;
                            d.valid       = 1'b0;
                            d.state       = ST_START;
                        end
                        default: begin
                            d.count = '0;
                            d.valid = 1'b0;
                            d.state = ST_IDLE;
                        end
                    endcase
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign run_req = q.run;
    assign count_o = q.count;
    assign busy_o  = (q.state != ST_IDLE);
    assign ready_o = q.valid;

    // R5: busy never rises without a command
    assert_on_demand_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(cmd_wr || q.pend_v));

    // R2: a completed result stays put until it is dropped
    assert_result_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> (!ready_o || $stable(count_o)));

    // R6: at most one oscillator is requested at a time
    assert_one_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(run_req));

    // R4: a valid result is never shown while a count is in progress
    assert_ready_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> !busy_o);
endmodule

// File: rtl/osc_drift_counter.sv
`timescale 1ns/1ps
module osc_drift_counter
    import osc_cnt_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hf_osc_clk,
    input  logic             lp_osc_clk,
    input  logic             cmd_wr,
    input  logic [1:0]       cmd_code,
    output logic [CNT_W-1:0] count_o,
    output logic             busy_o,
    output logic             ready_o
);
    logic [N_SRC-1:0]            osc_clks;
    logic [N_SRC-1:0]            run_req;
    logic [N_SRC-1:0]            ack_raw;
    logic [N_SRC-1:0]            ack_sync;
    logic [N_SRC-1:0][CNT_W-1:0] src_cnt;

    assign osc_clks = {lp_osc_clk, hf_osc_clk};

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        osc_cnt_core #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_core (
            .osc_clk(osc_clks[g]),
            .rst_n  (rst_n),
            .run_req(run_req[g]),
            .ack_o  (ack_raw[g]),
            .cnt_o  (src_cnt[g])
        );
    end

    osc_cnt_sync #(.STAGES(SYNC_STAGES), .WIDTH(N_SRC)) u_ack_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (ack_raw),
        .dout (ack_sync)
    );

    osc_cnt_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd_wr  (cmd_wr),
        .cmd_code(cmd_code),
        .ack_sync(ack_sync),
        .src_cnt (src_cnt),
        .run_req (run_req),
        .count_o (count_o),
        .busy_o  (busy_o),
        .ready_o (ready_o)
    );
endmodule

// File: tb/osc_drift_counter_bench.sv
`timescale 1ns/1ps
module osc_drift_counter_bench;
    logic        clk = 1'b0;
    logic        hf = 1'b0;
    logic        lp = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [1:0]  cmd_code = 2'd0;
    logic [15:0] count_o;
    logic        busy_o;
    logic        ready_o;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz system clock
    always #1   hf  = ~hf;    // fast oscillator, 2 ns period
    always #20  lp  = ~lp;    // slow oscillator, 40 ns period

    osc_drift_counter u_osc_drift_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .hf_osc_clk(hf),
        .lp_osc_clk(lp),
        .cmd_wr    (cmd_wr),
        .cmd_code  (cmd_code),
        .count_o   (count_o),
        .busy_o    (busy_o),
        .ready_o   (ready_o)
    );

    task automatic chk(string req, string what, int got, int lo, int hi);
        checks++;
        if (got < lo || got > hi) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, got, lo, hi);
        end
    endtask

    task automatic write_cmd(logic [1:0] c);
        @(negedge clk);
        cmd_wr   = 1'b1;
        cmd_code = c;
        @(negedge clk);
        cmd_wr   = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_quiet(string req);
        int n = 0;
        while (busy_o && n < 400) begin
            @(negedge clk);
            n++;
        end
        chk(req, "busy clears", int'(busy_o), 0, 0);
    endtask

    task automatic t_reset();
        chk("R8", "count after reset", int'(count_o), 0, 0);
        chk("R8", "busy after reset", int'(busy_o), 0, 0);
        chk("R8", "ready after reset", int'(ready_o), 0, 0);
        idle(200);
        chk("R5", "no start without command", int'(busy_o), 0, 0);
    endtask

    task automatic t_fast_window();
        write_cmd(2'd1);
        chk("R5", "busy during count", int'(busy_o), 1, 1);
        chk("R1", "ready cleared by start", int'(ready_o), 0, 0);
        idle(399);
        write_cmd(2'd3);
        wait_quiet("R2");
        chk("R2", "ready after stop", int'(ready_o), 1, 1);
        chk("R10", "fast count 2000 ns", int'(count_o), 996, 1004);
    endtask

    task automatic t_hold_and_idle_stop();
        logic [15:0] held = count_o;
        idle(300);
        chk("R2", "count held", int'(count_o), int'(held), int'(held));
        write_cmd(2'd3);
        idle(20);
        chk("R9", "idle stop keeps count", int'(count_o), int'(held), int'(held));
        chk("R9", "idle stop keeps ready", int'(ready_o), 1, 1);
    endtask

    task automatic t_slow_window();
        write_cmd(2'd2);
        idle(1599);
        write_cmd(2'd3);
        wait_quiet("R2");
        chk("R10", "slow count 8000 ns", int'(count_o), 196, 204);
    endtask

    task automatic t_same_source();
        write_cmd(2'd1);
        idle(199);
        write_cmd(2'd1);
        idle(199);
        write_cmd(2'd3);
        wait_quiet("R6");
        chk("R6", "same code ignored", int'(count_o), 996, 1004);
    endtask

    task automatic t_switch();
        write_cmd(2'd1);
        idle(199);
        write_cmd(2'd2);
        chk("R6", "busy through switch", int'(busy_o), 1, 1);
        idle(799);
        write_cmd(2'd3);
        wait_quiet("R6");
        chk("R6", "switched count from slow source", int'(count_o), 96, 104);
    endtask

    task automatic t_cancel();
        write_cmd(2'd2);
        idle(300);
        write_cmd(2'd0);
        wait_quiet("R4");
        chk("R4", "cancel ready", int'(ready_o), 0, 0);
        chk("R4", "cancel count", int'(count_o), 0, 0);
    endtask

    task automatic t_pending();
        @(negedge clk);
        cmd_wr = 1'b1; cmd_code = 2'd1;
        @(negedge clk);
        cmd_code = 2'd3;
        @(negedge clk);
        cmd_wr = 1'b0;
        wait_quiet("R7");
        chk("R7", "held stop applied", int'(ready_o), 1, 1);
        chk("R7", "short count", int'(count_o), 0, 40);
    endtask

    task automatic t_saturate();
        write_cmd(2'd1);
        idle(30000);
        write_cmd(2'd3);
        wait_quiet("R3");
        chk("R3", "saturated count", int'(count_o), 65535, 65535);
        write_cmd(2'd2);
        chk("R1", "restart clears count", int'(count_o), 0, 0);
        chk("R1", "restart clears ready", int'(ready_o), 0, 0);
        idle(100);
        write_cmd(2'd3);
        wait_quiet("R1");
        chk("R1", "fresh small count", int'(count_o), 8, 14);
    endtask

    initial begin
        idle(4);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fast_window();
        t_hold_and_idle_stop();
        t_slow_window();
        t_same_source();
        t_switch();
        t_cancel();
        t_pending();
        t_saturate();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(150000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule